// File: doc/BRIEF.md
# Peripheral Bus Chip-Select Decoder

This block sits between a host cycle source and a narrow, ISA-style peripheral bus. For every memory or I/O command it compares the cycle address against six programmable windows: a boot ROM window in the top 16 MB, a flash-disk window, two memory windows driven by base-address registers and two I/O ranges. It then drives at most one active-low chip select. Merged read and write strobes are produced for peripherals that do not tell memory and I/O apart. A second pair of strobes is qualified by the flash-disk select so that a flash controller can be wired directly.

A command that no window claims can be handed to the internal ISA bus by subtractive decode. Subtractive decode is enabled separately for memory cycles and for I/O cycles. For each claimed cycle the block reports the data width and whether zero wait states apply. All decode outputs are combinational from the command strobes and the registered configuration. A small synchronous register port holds the bases, masks, enables and device attributes. It also exposes a refresh-toggle status bit that flips on a fixed period, although the block never runs a refresh cycle.

Register map (index on `cfg_addr`): 0 ROM mask [3:0]; 1/2 flash-disk base/mask; 3/4 BAR-A base/mask; 5/6 BAR-B base/mask; 7/8 I/O range 0/1 with base [15:0] and mask [31:16]; 9 enables; 10 attributes; 11 status. Select vector bit order on `cs_n`: 0 ROM, 1 flash-disk, 2 BAR-A, 3 BAR-B, 4 I/O range 0, 5 I/O range 1.

Top module: `sisa_cs_decoder`

## Requirements
- R1: `rd_n` is low exactly when `io_rd_n` or `mem_rd_n` is low, and `wr_n` is low exactly when `io_wr_n` or `mem_wr_n` is low.
- R2: The ROM select (`cs_n[0]`) is low on a memory cycle when address bits [31:24] are all ones, the ROM enable is set, and every address bit [23:20] whose bit in register 0 [3:0] is set is also one. A mask of zero covers the whole top 16 MB.
- R3: A memory window hits on memory cycles only, when `(addr ^ base) & mask` is zero and its enable is set. The flash-disk window uses registers 1 and 2, and its base is expected to be aligned to the window size.
- R4: `dsk_rd_n` is low exactly while `cs_n[1]` and `mem_rd_n` are both low, and `dsk_wr_n` is low exactly while `cs_n[1]` and `mem_wr_n` are both low.
- R5: The I/O ranges hit on I/O cycles only, comparing address bits [15:0] against their base under their mask. A memory cycle to the same low address never asserts them.
- R6: The two BAR windows (`cs_n[2]`, `cs_n[3]`) hit only when their enable bits, register 9 bits 2 and 3, are set. Register 9 bits [5:0] enable the six windows in select order.
- R7: When several windows hit, only the lowest-numbered select is asserted, so that ROM beats flash-disk, which beats BAR-A, then BAR-B, then I/O range 0 and then I/O range 1. No more than one select is ever low.
- R8: `fwd_isa` is high on an unclaimed memory cycle when register 9 bit 6 is set, and on an unclaimed I/O cycle when register 9 bit 7 is set. It is low whenever any select is asserted.
- R9: For a claimed cycle, `width16` equals the select's bit in register 10 [5:0]. `zero_ws` equals its bit in register 10 [13:8], except that an I/O range set to 16-bit never reports zero wait states. Unclaimed cycles report 8-bit with wait states (both low).
- R10: With no command strobe low, every select, `dsk_rd_n`, `dsk_wr_n` and `fwd_isa` is inactive. If a memory and an I/O strobe are low together, the cycle is decoded as memory.
- R11: Register 11 bit 0 flips once every `REFRESH_DIV` clock cycles, and writes to register 11 do not affect it.
- R12: After reset, register 9 reads 0xC1, so that only the ROM window and both subtractive paths are enabled, and every other register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| cyc_addr | input | 32 | Cycle address (I/O uses bits [15:0]) |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| cs_n | output | 6 | Chip selects, active low, order as above |
| rd_n | output | 1 | Merged read strobe |
| wr_n | output | 1 | Merged write strobe |
| dsk_rd_n | output | 1 | Flash-disk qualified read strobe |
| dsk_wr_n | output | 1 | Flash-disk qualified write strobe |
| fwd_isa | output | 1 | Cycle forwarded by subtractive decode |
| width16 | output | 1 | Claimed device is 16-bit |
| zero_ws | output | 1 | Claimed device runs with zero wait states |

## Verification
Positive decode and subtractive forwarding compete for the same cycle. The bench provokes this by placing a command on an address just outside a window, then moving the window or enabling it so that the same address is claimed, and judges that `fwd_isa` falls exactly when a select rises. Window priority is exercised in the same way: an enabled BAR window is laid over the ROM range, and the ROM enable is then cleared, so the bench can observe which single select wins in each case. The attribute outputs are checked in those same cycles, including the case of a 16-bit I/O device that asks for zero wait states.

// File: rtl/sisa_pkg.sv
// Package: shared constants and configuration type for the chip-select decoder.
// Assumes six fixed windows in priority order; memory windows come first.
package sisa_pkg;
    localparam int MEM_AW = 32;
    localparam int IO_AW  = 16;
    localparam int NSEL   = 6;
    localparam int NMEM   = 4;
    localparam int SEL_ROM = 0;
    localparam int SEL_DSK = 1;

    localparam logic [3:0] RG_ROM    = 4'd0;
    localparam logic [3:0] RG_DSK_B  = 4'd1;
    localparam logic [3:0] RG_DSK_M  = 4'd2;
    localparam logic [3:0] RG_BRA_B  = 4'd3;
    localparam logic [3:0] RG_BRA_M  = 4'd4;
    localparam logic [3:0] RG_BRB_B  = 4'd5;
    localparam logic [3:0] RG_BRB_M  = 4'd6;
    localparam logic [3:0] RG_IO0    = 4'd7;
    localparam logic [3:0] RG_IO1    = 4'd8;
    localparam logic [3:0] RG_EN     = 4'd9;
    localparam logic [3:0] RG_ATTR   = 4'd10;
    localparam logic [3:0] RG_STAT   = 4'd11;

    typedef struct packed {
        logic [3:0]        rom_mask;
        logic [MEM_AW-1:0] dsk_base;
        logic [MEM_AW-1:0] dsk_mask;
        logic [MEM_AW-1:0] bra_base;
        logic [MEM_AW-1:0] bra_mask;
        logic [MEM_AW-1:0] brb_base;
        logic [MEM_AW-1:0] brb_mask;
        logic [IO_AW-1:0]  io0_base;
        logic [IO_AW-1:0]  io0_mask;
        logic [IO_AW-1:0]  io1_base;
        logic [IO_AW-1:0]  io1_mask;
        logic [NSEL-1:0]   win_en;
        logic              sub_mem_en;
        logic              sub_io_en;
        logic [NSEL-1:0]   w16;
        logic [NSEL-1:0]   zws;
    } sisa_cfg_t;
endpackage

// File: rtl/sisa_cfg_regs.sv
// Module: configuration register file with combinational read-back and a
// free-running refresh-toggle status bit. Assumes single-cycle writes.
module sisa_cfg_regs
    import sisa_pkg::*;
#(
    parameter int REFRESH_DIV = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output sisa_cfg_t   cfg
);
    localparam int CW = (REFRESH_DIV > 2) ? $clog2(REFRESH_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(REFRESH_DIV - 1);

    logic [CW-1:0] ref_cnt;
    logic          ref_tgl;

    // Register writes; reset leaves only the ROM window and subtractive paths on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg            <= '0;
            cfg.win_en     <= 6'b000001;
            cfg.sub_mem_en <= 1'b1;
            cfg.sub_io_en  <= 1'b1;
        end else if (we) begin
            case (addr)
                RG_ROM:   cfg.rom_mask <= wdata[3:0];
                RG_DSK_B: cfg.dsk_base <= wdata;
                RG_DSK_M: cfg.dsk_mask <= wdata;
                RG_BRA_B: cfg.bra_base <= wdata;
                RG_BRA_M: cfg.bra_mask <= wdata;
                RG_BRB_B: cfg.brb_base <= wdata;
                RG_BRB_M: cfg.brb_mask <= wdata;
                RG_IO0:   {cfg.io0_mask, cfg.io0_base} <= wdata;
                RG_IO1:   {cfg.io1_mask, cfg.io1_base} <= wdata;
                RG_EN:    {cfg.sub_io_en, cfg.sub_mem_en, cfg.win_en} <= wdata[7:0];
                RG_ATTR:  begin
                    cfg.w16 <= wdata[5:0];
                    cfg.zws <= wdata[13:8];
                end
                default: ;
            endcase
        end
    end

    // Refresh-toggle divider: flips the status bit once per REFRESH_DIV cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= '0;
            ref_tgl <= 1'b0;
        end else if (ref_cnt == CNT_LAST) begin
            ref_cnt <= '0;
            ref_tgl <= ~ref_tgl;
        end else begin
            ref_cnt <= ref_cnt + 1'b1;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            RG_ROM:   rdata = {28'b0, cfg.rom_mask};
            RG_DSK_B: rdata = cfg.dsk_base;
            RG_DSK_M: rdata = cfg.dsk_mask;
            RG_BRA_B: rdata = cfg.bra_base;
            RG_BRA_M: rdata = cfg.bra_mask;
            RG_BRB_B: rdata = cfg.brb_base;
            RG_BRB_M: rdata = cfg.brb_mask;
            RG_IO0:   rdata = {cfg.io0_mask, cfg.io0_base};
            RG_IO1:   rdata = {cfg.io1_mask, cfg.io1_base};
            RG_EN:    rdata = {24'b0, cfg.sub_io_en, cfg.sub_mem_en, cfg.win_en};
            RG_ATTR:  rdata = {18'b0, cfg.zws, 2'b0, cfg.w16};
            RG_STAT:  rdata = {31'b0, ref_tgl};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/sisa_win_match.sv
// Module: one masked address window comparator. A hit needs the enable, the
// cycle-type qualifier and equality on every address bit the mask selects.
module sisa_win_match #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    input  logic          en,
    input  logic          qual,
    output logic          hit
);
    // Masked compare.
    always_comb hit = en & qual & (((addr ^ base) & mask) == '0);
endmodule

// File: rtl/sisa_prio_sel.sv
// Module: fixed-priority one-hot picker; bit 0 has the highest priority.
module sisa_prio_sel #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // Scan from lowest priority upward so the lowest set index wins last.
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sisa_cs_decoder.sv
// Module: top of the peripheral-bus chip-select decoder. Decodes each command
// combinationally against six windows, picks one select by priority, and
// decides subtractive forwarding and device attributes. Assumes command
// strobes are active low; a memory strobe wins over a concurrent I/O strobe.
module sisa_cs_decoder
    import sisa_pkg::*;
#(
    parameter int REFRESH_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [MEM_AW-1:0] cyc_addr,
    input  logic              mem_rd_n,
    input  logic              mem_wr_n,
    input  logic              io_rd_n,
    input  logic              io_wr_n,
    output logic [NSEL-1:0]   cs_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              dsk_rd_n,
    output logic              dsk_wr_n,
    output logic              fwd_isa,
    output logic              width16,
    output logic              zero_ws
);
    localparam logic [NSEL-1:0] IO_SELS = {{(NSEL-NMEM){1'b1}}, {NMEM{1'b0}}};

    sisa_cfg_t         cfg;
    logic              mem_cyc, io_cyc;
    logic [MEM_AW-1:0] io_addr_x;
    logic [MEM_AW-1:0] rom_pat;
    logic [MEM_AW-1:0] base_a [NSEL];
    logic [MEM_AW-1:0] mask_a [NSEL];
    logic [NSEL-1:0]   hit, gnt;

    sisa_cfg_regs #(.REFRESH_DIV(REFRESH_DIV)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    // Cycle classification; memory takes precedence.
    always_comb begin
        mem_cyc   = ~mem_rd_n | ~mem_wr_n;
        io_cyc    = (~io_rd_n | ~io_wr_n) & ~mem_cyc;
        io_addr_x = {{(MEM_AW-IO_AW){1'b0}}, cyc_addr[IO_AW-1:0]};
    end

    // Window table: ROM pattern doubles as base and mask; I/O masks zero-extend.
    always_comb begin
        rom_pat   = {8'hFF, cfg.rom_mask, 20'h0};
        base_a[0] = rom_pat;                     mask_a[0] = rom_pat;
        base_a[1] = cfg.dsk_base;                mask_a[1] = cfg.dsk_mask;
        base_a[2] = cfg.bra_base;                mask_a[2] = cfg.bra_mask;
        base_a[3] = cfg.brb_base;                mask_a[3] = cfg.brb_mask;
        base_a[4] = {16'b0, cfg.io0_base};       mask_a[4] = {16'b0, cfg.io0_mask};
        base_a[5] = {16'b0, cfg.io1_base};       mask_a[5] = {16'b0, cfg.io1_mask};
    end

    for (genvar g = 0; g < NSEL; g++) begin : g_win
        if (g < NMEM) begin : g_mem
            sisa_win_match #(.AW(MEM_AW)) u_win (
                .addr (cyc_addr), .base (base_a[g]), .mask (mask_a[g]),
                .en (cfg.win_en[g]), .qual (mem_cyc), .hit (hit[g])
            );
        end else begin : g_io
            sisa_win_match #(.AW(MEM_AW)) u_win (
                .addr (io_addr_x), .base (base_a[g]), .mask (mask_a[g]),
                .en (cfg.win_en[g]), .qual (io_cyc), .hit (hit[g])
            );
        end
    end

    sisa_prio_sel #(.N(NSEL)) u_prio (
        .req (hit),
        .gnt (gnt)
    );

    // Output strobes, forwarding and device attributes.
    always_comb begin
        cs_n     = ~gnt;
        rd_n     = io_rd_n & mem_rd_n;
        wr_n     = io_wr_n & mem_wr_n;
        dsk_rd_n = ~(gnt[SEL_DSK] & ~mem_rd_n);
        dsk_wr_n = ~(gnt[SEL_DSK] & ~mem_wr_n);
        fwd_isa  = ~(|gnt) & ((mem_cyc & cfg.sub_mem_en) | (io_cyc & cfg.sub_io_en));
        width16  = |(gnt & cfg.w16);
        zero_ws  = |(gnt & cfg.zws & ~(IO_SELS & cfg.w16));
    end
endmodule

// File: rtl/sisa_cs_checker.sv
// Module: protocol checker for the chip-select decoder, bound to the top.
module sisa_cs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_rd_n,
    input logic       mem_wr_n,
    input logic       io_rd_n,
    input logic       io_wr_n,
    input logic [5:0] cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       dsk_rd_n,
    input logic       dsk_wr_n,
    input logic       fwd_isa,
    input logic       width16,
    input logic       zero_ws
);
    logic no_cmd;
    always_comb no_cmd = mem_rd_n & mem_wr_n & io_rd_n & io_wr_n;

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        no_cmd |-> (cs_n == 6'h3F && !fwd_isa && dsk_rd_n && dsk_wr_n)); // R10
    AST_DSK_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !dsk_rd_n |-> (!cs_n[1] && !mem_rd_n)); // R4
    AST_DSK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !dsk_wr_n |-> (!cs_n[1] && !mem_wr_n)); // R4
    AST_MERGED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd_n || !mem_rd_n) |-> !rd_n); // R1
    AST_MERGED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr_n || !mem_wr_n) |-> !wr_n); // R1
    AST_FWD_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_isa |-> (cs_n == 6'h3F)); // R8
    AST_IO_ZWS_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cs_n[4] || !cs_n[5]) && zero_ws) |-> !width16); // R9
    AST_UNCLAIMED_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == 6'h3F) |-> (!width16 && !zero_ws)); // R9
endmodule

bind sisa_cs_decoder sisa_cs_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .io_rd_n  (io_rd_n),
    .io_wr_n  (io_wr_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .dsk_rd_n (dsk_rd_n),
    .dsk_wr_n (dsk_wr_n),
    .fwd_isa  (fwd_isa),
    .width16  (width16),
    .zero_ws  (zero_ws)
);

// File: tb/sisa_cs_decoder_tb.sv
// Directed bench for the chip-select decoder: one task per scenario.
module sisa_cs_decoder_tb;
    localparam int RDIV = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] cyc_addr = '0;
    logic        mem_rd_n = 1'b1, mem_wr_n = 1'b1, io_rd_n = 1'b1, io_wr_n = 1'b1;
    logic [5:0]  cs_n;
    logic        rd_n, wr_n, dsk_rd_n, dsk_wr_n, fwd_isa, width16, zero_ws;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sisa_cs_decoder #(.REFRESH_DIV(RDIV)) u_dut (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .cyc_addr, .mem_rd_n, .mem_wr_n, .io_rd_n, .io_wr_n,
        .cs_n, .rd_n, .wr_n, .dsk_rd_n, .dsk_wr_n, .fwd_isa, .width16, .zero_ws
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // kind: 0 mem read, 1 mem write, 2 io read, 3 io write
    task automatic cmd(int kind, logic [31:0] a);
        @(negedge clk);
        cyc_addr = a;
        mem_rd_n = !(kind == 0); mem_wr_n = !(kind == 1);
        io_rd_n  = !(kind == 2); io_wr_n  = !(kind == 3);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        mem_rd_n = 1'b1; mem_wr_n = 1'b1; io_rd_n = 1'b1; io_wr_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        #1;
        chk("R12 cs idle", {26'b0, cs_n}, 32'h3F);
        rd_reg(4'd9, d);  chk("R12 enable reset", d, 32'hC1);
        rd_reg(4'd1, d);  chk("R12 dsk base reset", d, 0);
        rd_reg(4'd10, d); chk("R12 attr reset", d, 0);
        chk("R10 fwd idle", {31'b0, fwd_isa}, 0);
    endtask

    task automatic t_merged();
        cmd(2, 32'h0000_0100);
        chk("R1 io read rd", {30'b0, rd_n, wr_n}, 32'h1);
        cmd(1, 32'h0000_0100);
        chk("R1 mem write wr", {30'b0, rd_n, wr_n}, 32'h2);
        idle();
        chk("R1 idle", {30'b0, rd_n, wr_n}, 32'h3);
    endtask

    task automatic t_rom();
        cmd(0, 32'hFF00_1000); chk("R2 rom full", {26'b0, cs_n}, 32'h3E);
        cmd(0, 32'hFE00_1000); chk("R2 below rom", {26'b0, cs_n}, 32'h3F);
        idle();
        wr_reg(4'd0, 32'h8);
        cmd(0, 32'hFF00_1000); chk("R2 masked out", {26'b0, cs_n}, 32'h3F);
        chk("R8 masked out forwarded", {31'b0, fwd_isa}, 1);
        cmd(0, 32'hFF80_0000); chk("R2 masked in", {26'b0, cs_n}, 32'h3E);
        chk("R8 claimed not forwarded", {31'b0, fwd_isa}, 0);
        idle();
        wr_reg(4'd0, 32'h0);
    endtask

    task automatic t_dsk();
        wr_reg(4'd1, 32'h000D_0000);
        wr_reg(4'd2, 32'hFFFF_0000);
        wr_reg(4'd9, 32'hC3);
        cmd(0, 32'h000D_1234);
        chk("R3 dsk read sel", {26'b0, cs_n}, 32'h3D);
        chk("R4 dsk rd/wr on read", {30'b0, dsk_rd_n, dsk_wr_n}, 32'h1);
        cmd(1, 32'h000D_FFFF);
        chk("R4 dsk rd/wr on write", {30'b0, dsk_rd_n, dsk_wr_n}, 32'h2);
        cmd(0, 32'h000E_0000);
        chk("R3 outside window", {26'b0, cs_n}, 32'h3F);
        chk("R4 no dsk strobe outside", {30'b0, dsk_rd_n, dsk_wr_n}, 32'h3);
        cmd(2, 32'h000D_1234);
        chk("R3 io cycle no dsk", {26'b0, cs_n}, 32'h3F);
        idle();
    endtask

    task automatic t_io();
        wr_reg(4'd7, 32'hFFF0_0300);
        wr_reg(4'd9, 32'hD3);
        cmd(2, 32'h0000_0305); chk("R5 io0 read", {26'b0, cs_n}, 32'h2F);
        cmd(3, 32'hABCD_030F); chk("R5 io0 write upper ignored", {26'b0, cs_n}, 32'h2F);
        cmd(0, 32'h0000_0305); chk("R5 mem no io sel", {26'b0, cs_n}, 32'h3F);
        idle();
        @(negedge clk);
        cyc_addr = 32'h0000_0305; mem_rd_n = 1'b0; io_rd_n = 1'b0; #1;
        chk("R10 mem wins over io", {26'b0, cs_n}, 32'h3F);
        idle();
        chk("R10 quiet after", {26'b0, cs_n}, 32'h3F);
    endtask

    task automatic t_bar();
        wr_reg(4'd3, 32'h8000_0000);
        wr_reg(4'd4, 32'hFF00_0000);
        cmd(0, 32'h8012_3456);
        chk("R6 bar disabled", {26'b0, cs_n}, 32'h3F);
        chk("R8 disabled bar forwarded", {31'b0, fwd_isa}, 1);
        idle();
        wr_reg(4'd9, 32'hD7);
        cmd(0, 32'h8012_3456);
        chk("R6 bar enabled", {26'b0, cs_n}, 32'h3B);
        chk("R8 bar claim stops fwd", {31'b0, fwd_isa}, 0);
        idle();
    endtask

    task automatic t_prio();
        wr_reg(4'd5, 32'h8000_0000);
        wr_reg(4'd6, 32'hFF00_0000);
        wr_reg(4'd9, 32'hDF);
        cmd(0, 32'h8000_0010); chk("R7 bar-a over bar-b", {26'b0, cs_n}, 32'h3B);
        idle();
        wr_reg(4'd3, 32'hFF00_0000);
        cmd(0, 32'hFF12_0000); chk("R7 rom over bar-a", {26'b0, cs_n}, 32'h3E);
        idle();
        wr_reg(4'd9, 32'hDE);
        cmd(0, 32'hFF12_0000); chk("R7 bar-a after rom off", {26'b0, cs_n}, 32'h3B);
        cmd(0, 32'h8000_0010); chk("R7 bar-b alone", {26'b0, cs_n}, 32'h37);
        idle();
        wr_reg(4'd9, 32'hD3);
    endtask

    task automatic t_sub();
        wr_reg(4'd9, 32'h93);
        cmd(0, 32'h1234_0000); chk("R8 mem sub off", {31'b0, fwd_isa}, 0);
        cmd(2, 32'h0000_0600); chk("R8 io sub on", {31'b0, fwd_isa}, 1);
        idle();
        wr_reg(4'd9, 32'h53);
        cmd(2, 32'h0000_0600); chk("R8 io sub off", {31'b0, fwd_isa}, 0);
        cmd(1, 32'h1234_0000); chk("R8 mem sub on", {31'b0, fwd_isa}, 1);
        idle();
        wr_reg(4'd9, 32'hD3);
    endtask

    task automatic t_attr();
        wr_reg(4'd10, 32'h0000_1111);
        cmd(0, 32'hFF00_0000);
        chk("R9 rom 16 zws", {30'b0, width16, zero_ws}, 32'h3);
        cmd(2, 32'h0000_0301);
        chk("R9 io 16-bit no zws", {30'b0, width16, zero_ws}, 32'h2);
        idle();
        wr_reg(4'd10, 32'h0000_1101);
        cmd(2, 32'h0000_0301);
        chk("R9 io 8-bit zws", {30'b0, width16, zero_ws}, 32'h1);
        cmd(0, 32'h4000_0000);
        chk("R9 unclaimed 8-bit waits", {30'b0, width16, zero_ws}, 32'h0);
        idle();
    endtask

    task automatic t_refresh();
        logic [31:0] a, b;
        rd_reg(4'd11, a);
        wr_reg(4'd11, {31'b0, a[0]});
        repeat (RDIV - 3) @(negedge clk);
        rd_reg(4'd11, b);
        chk("R11 toggles once per period, write ignored", {31'b0, b[0]}, {31'b0, ~a[0]});
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_merged();
        t_rom();
        t_dsk();
        t_io();
        t_bar();
        t_prio();
        t_sub();
        t_attr();
        t_refresh();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule